// File: doc/BRIEF.md
# Superpage-Aware Translation Lookaside Buffer

This block is a small, fully associative translation cache for a three-level, 39-bit virtual memory scheme. The 27-bit virtual page number is made of three 9-bit fields. Each entry maps one page, and that page can be 1 GiB, 2 MiB or 4 KiB. A 2-bit level field in the entry sets how many of the upper VPN fields are compared with the stored tag. The same field sets how many low VPN bits pass straight into the physical page number that the block returns.

A lookup is combinational. The block takes a VPN and a 3-bit access command. In the same cycle it returns a hit flag, the physical page number and two fault flags, one for a page fault and one for an access fault. The fault flags depend on the access type, on the stored permission bits and on any fault flags the walker stored with the entry.

Entries are written through a single refill port. The page walker supplies the target way, the tag, the level, the PPN, seven permission bits and its two fault flags, and the write takes effect at the next clock edge. A flush input invalidates every entry in one cycle.

Top module: `tlbsp_top`

## Requirements
- R1: After a synchronous active-low reset no entry is valid, so every lookup misses.
- R2: A refill with fill_valid high writes the entry in way fill_way at the next rising edge. A level 2 (4 KiB) entry then hits only when all 27 VPN bits equal the tag, and it returns the stored PPN unchanged.
- R3: A level 1 (2 MiB) entry hits when VPN bits 26:9 equal those of the tag. On a hit, PPN bits 8:0 are taken from VPN bits 8:0 and the upper PPN bits come from the entry.
- R4: A level 0 (1 GiB) entry hits when VPN bits 26:18 equal those of the tag. On a hit, PPN bits 17:0 are taken from VPN bits 17:0.
- R5: An entry written with level 3 never hits.
- R6: The lookup command is 3 bits wide. Bits 1:0 give the access kind: 00 is read, 01 is write, 10 is execute and 11 is reserved. Bit 2 marks an atomic access, so 100 is a reserved load and 101 is a conditional store or atomic update. The permission bits are indexed as R=0, W=1, X=2, U=3, G=4, A=5, D=6. When a hitting entry has no stored page fault, a page fault is raised if the access lacks its permission: a read needs R, a write needs W and an execute needs X. Kind 11 always faults.
- R7: When a hitting entry has no stored page fault, a clear A bit raises a page fault for any access, and a write raises a page fault if D is clear.
- R8: A page-fault flag stored with a hitting entry raises page_fault whatever the permission bits are. A stored access-fault flag raises access_fault.
- R9: When more than one entry matches, the entry with the lowest index supplies the PPN and the permissions.
- R10: On a miss, hit, phys_pn, page_fault and access_fault are all zero.
- R11: flush_all clears every valid bit at the next edge. A refill in the same cycle is dropped.
- R12: A refill to an occupied way replaces the old mapping completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lkp_vpn | input | 27 | Lookup virtual page number |
| lkp_cmd | input | 3 | Lookup access command |
| hit | output | 1 | Lookup matched a valid entry |
| phys_pn | output | 44 | Translated physical page number |
| page_fault | output | 1 | Page fault for this access |
| access_fault | output | 1 | Access fault for this access |
| fill_valid | input | 1 | Refill write strobe |
| fill_way | input | 3 | Entry index to write |
| fill_vpn | input | 27 | Refill tag |
| fill_level | input | 2 | Refill page level (0: 1 GiB, 1: 2 MiB, 2: 4 KiB) |
| fill_ppn | input | 44 | Refill physical page number |
| fill_perm | input | 7 | Refill permission bits, indexed as in R6 |
| fill_pf | input | 1 | Walker reported a page fault |
| fill_af | input | 1 | Walker reported an access fault |
| flush_all | input | 1 | Invalidate every entry |

## Verification
Each page size is tested with a lookup VPN whose low fields differ from the tag. This shows whether only the right number of fields takes part in the compare. A second VPN that differs in the lowest compared field must miss, which shows whether too few fields are compared. The same lookups check that exactly the right low bits pass into the returned PPN.

Permission checks sweep all command codes against entries that hold only R, only X, or everything except A or D. This separates the check on each needed bit from the A and D rules. Stored fault flags are tested on entries that hold full permissions. An overlapping 1 GiB and 4 KiB pair shows which entry wins. A refill given in the same cycle as a flush must leave no trace.

// File: rtl/tlbsp_pkg.sv
// Package: shared constants for the superpage translation buffer.
// Assumes the permission vector and the command layout listed in the brief.
package tlbsp_pkg;
    localparam int PERM_W = 7;
    localparam int PB_R   = 0;
    localparam int PB_W   = 1;
    localparam int PB_X   = 2;
    localparam int PB_U   = 3;
    localparam int PB_G   = 4;
    localparam int PB_A   = 5;
    localparam int PB_D   = 6;

    localparam logic [1:0] KIND_READ  = 2'b00;
    localparam logic [1:0] KIND_WRITE = 2'b01;
    localparam logic [1:0] KIND_EXEC  = 2'b10;
endpackage

// File: rtl/tlbsp_store.sv
// Module: entry storage. Holds valid, tag, level, PPN, permissions and the
// stored fault flags for every way. Assumes fill_way < ENTRIES. Flush has
// priority over a refill in the same cycle, and reset has priority over both.
module tlbsp_store
    import tlbsp_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 27,
    parameter int PPN_W   = 44,
    parameter int LVL_W   = 2,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_way,
    input  logic [VPN_W-1:0]                  wr_tag,
    input  logic [LVL_W-1:0]                  wr_level,
    input  logic [PPN_W-1:0]                  wr_ppn,
    input  logic [PERM_W-1:0]                 wr_perm,
    input  logic                              wr_pf,
    input  logic                              wr_af,
    input  logic                              clear_all,
    output logic [ENTRIES-1:0]                ent_valid,
    output logic [ENTRIES-1:0][VPN_W-1:0]     ent_tag,
    output logic [ENTRIES-1:0][LVL_W-1:0]     ent_level,
    output logic [ENTRIES-1:0][PPN_W-1:0]     ent_ppn,
    output logic [ENTRIES-1:0][PERM_W-1:0]    ent_perm,
    output logic [ENTRIES-1:0]                ent_pf,
    output logic [ENTRIES-1:0]                ent_af
);
    for (genvar w = 0; w < ENTRIES; w++) begin : g_way
        logic sel_w;
        assign sel_w = wr_en && (wr_way == IDX_W'(w));

        // Valid bit: cleared by reset or flush, set by a refill to this way.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_all) begin
                ent_valid[w] <= 1'b0;
            end else if (sel_w) begin
                ent_valid[w] <= 1'b1;
            end
        end

        // Payload: captured on a refill to this way that no flush overrides.
        always_ff @(posedge clk) begin
            if (rst_n && !clear_all && sel_w) begin
                ent_tag[w]   <= wr_tag;
                ent_level[w] <= wr_level;
                ent_ppn[w]   <= wr_ppn;
                ent_perm[w]  <= wr_perm;
                ent_pf[w]    <= wr_pf;
                ent_af[w]    <= wr_af;
            end
        end
    end
endmodule

// File: rtl/tlbsp_match.sv
// Module: per-entry tag compare and PPN composition, then a lowest-index
// priority pick. Assumes VPN_W == FIELD_W*LEVELS and PPN_W >= VPN_W.
// A level value of LEVELS or more never matches.
module tlbsp_match
    import tlbsp_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int FIELD_W = 9,
    parameter int LEVELS  = 3,
    parameter int PPN_W   = 44,
    localparam int VPN_W  = FIELD_W * LEVELS,
    localparam int LVL_W  = $clog2(LEVELS + 1),
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [VPN_W-1:0]                  q_vpn,
    input  logic [ENTRIES-1:0]                ent_valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0]     ent_tag,
    input  logic [ENTRIES-1:0][LVL_W-1:0]     ent_level,
    input  logic [ENTRIES-1:0][PPN_W-1:0]     ent_ppn,
    output logic                              any_hit,
    output logic [IDX_W-1:0]                  hit_idx,
    output logic [PPN_W-1:0]                  hit_ppn
);
    // Mask of the VPN bits that pass through for a given level.
    function automatic logic [VPN_W-1:0] pass_mask(input logic [LVL_W-1:0] lvl);
        logic [VPN_W-1:0] m;
        m = '0;
        for (int k = 0; k < LEVELS; k++) begin
            if (int'(lvl) == k) begin
                m = (VPN_W'(1) << (FIELD_W * (LEVELS - 1 - k))) - VPN_W'(1);
            end
        end
        return m;
    endfunction

    logic [ENTRIES-1:0]            way_hit;
    logic [ENTRIES-1:0][PPN_W-1:0] way_ppn;

    for (genvar w = 0; w < ENTRIES; w++) begin : g_cmp
        logic [VPN_W-1:0] pm;
        logic             lvl_ok;

        // Compare the fields the level selects and splice in the low VPN bits.
        always_comb begin
            pm         = pass_mask(ent_level[w]);
            lvl_ok     = int'(ent_level[w]) < LEVELS;
            way_hit[w] = ent_valid[w] && lvl_ok
                         && (((ent_tag[w] ^ q_vpn) & ~pm) == '0);
            way_ppn[w] = (ent_ppn[w] & ~{{(PPN_W-VPN_W){1'b0}}, pm})
                         | {{(PPN_W-VPN_W){1'b0}}, (q_vpn & pm)};
        end
    end

    // Priority pick: scan downward so the lowest matching index remains.
    always_comb begin
        any_hit = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (way_hit[i]) begin
                any_hit = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
        hit_ppn = any_hit ? way_ppn[hit_idx] : '0;
    end
endmodule

// File: rtl/tlbsp_fault.sv
// Module: fault decision for the selected entry. Assumes the command and
// permission encodings from tlbsp_pkg. Gives no fault when there is no hit.
module tlbsp_fault
    import tlbsp_pkg::*;
(
    input  logic              any_hit,
    input  logic [2:0]        cmd,
    input  logic [PERM_W-1:0] perm,
    input  logic              st_pf,
    input  logic              st_af,
    output logic              pf_out,
    output logic              af_out
);
    logic kind_ok;

    // Required-permission check, then the stored flags and the A/D rules.
    always_comb begin
        unique case (cmd[1:0])
            KIND_READ:  kind_ok = perm[PB_R];
            KIND_WRITE: kind_ok = perm[PB_W] && perm[PB_D];
            KIND_EXEC:  kind_ok = perm[PB_X];
            default:    kind_ok = 1'b0;
        endcase
        af_out = any_hit && st_af;
        pf_out = any_hit && (st_pf || !kind_ok || !perm[PB_A]);
    end
endmodule

// File: rtl/tlbsp_top.sv
// Module: superpage-aware fully associative translation buffer.
// Lookup is combinational. A refill or a flush takes effect at the next edge.
// Assumes the walker supplies an in-range way index on every refill.
module tlbsp_top
    import tlbsp_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int FIELD_W = 9,
    parameter int LEVELS  = 3,
    parameter int PPN_W   = 44,
    localparam int VPN_W  = FIELD_W * LEVELS,
    localparam int LVL_W  = $clog2(LEVELS + 1),
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lkp_vpn,
    input  logic [2:0]        lkp_cmd,
    output logic              hit,
    output logic [PPN_W-1:0]  phys_pn,
    output logic              page_fault,
    output logic              access_fault,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_way,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [LVL_W-1:0]  fill_level,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              fill_pf,
    input  logic              fill_af,
    input  logic              flush_all
);
    logic [ENTRIES-1:0]             e_valid;
    logic [ENTRIES-1:0][VPN_W-1:0]  e_tag;
    logic [ENTRIES-1:0][LVL_W-1:0]  e_level;
    logic [ENTRIES-1:0][PPN_W-1:0]  e_ppn;
    logic [ENTRIES-1:0][PERM_W-1:0] e_perm;
    logic [ENTRIES-1:0]             e_pf;
    logic [ENTRIES-1:0]             e_af;
    logic [IDX_W-1:0]               sel;

    tlbsp_store #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .LVL_W(LVL_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(fill_valid), .wr_way(fill_way), .wr_tag(fill_vpn),
        .wr_level(fill_level), .wr_ppn(fill_ppn), .wr_perm(fill_perm),
        .wr_pf(fill_pf), .wr_af(fill_af), .clear_all(flush_all),
        .ent_valid(e_valid), .ent_tag(e_tag), .ent_level(e_level),
        .ent_ppn(e_ppn), .ent_perm(e_perm), .ent_pf(e_pf), .ent_af(e_af)
    );

    tlbsp_match #(
        .ENTRIES(ENTRIES), .FIELD_W(FIELD_W), .LEVELS(LEVELS), .PPN_W(PPN_W)
    ) match_i (
        .q_vpn(lkp_vpn), .ent_valid(e_valid), .ent_tag(e_tag),
        .ent_level(e_level), .ent_ppn(e_ppn),
        .any_hit(hit), .hit_idx(sel), .hit_ppn(phys_pn)
    );

    tlbsp_fault fault_i (
        .any_hit(hit), .cmd(lkp_cmd), .perm(e_perm[sel]),
        .st_pf(e_pf[sel]), .st_af(e_af[sel]),
        .pf_out(page_fault), .af_out(access_fault)
    );
endmodule

// File: rtl/tlbsp_checker.sv
// Module: temporal checks on the translation buffer ports, bound to the top.
module tlbsp_checker #(
    parameter int VPN_W = 27,
    parameter int PPN_W = 44,
    parameter int LVL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [VPN_W-1:0] lkp_vpn,
    input logic [2:0]       lkp_cmd,
    input logic             hit,
    input logic [PPN_W-1:0] phys_pn,
    input logic             page_fault,
    input logic             access_fault,
    input logic             fill_valid,
    input logic [VPN_W-1:0] fill_vpn,
    input logic [LVL_W-1:0] fill_level,
    input logic             flush_all
);
    // R10
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (phys_pn == '0 && !page_fault && !access_fault));

    // R11
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !hit);

    // R2
    fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush_all && fill_level != 2'd3)
        |=> (lkp_vpn != $past(fill_vpn) || hit));

    // R6
    reserved_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && lkp_cmd[1:0] == 2'b11) |-> page_fault);

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !hit);
endmodule

bind tlbsp_top tlbsp_checker #(.VPN_W(VPN_W), .PPN_W(PPN_W), .LVL_W(LVL_W)) chk_i (.*);

// File: tb/tlbsp_top_tb_top.sv
// Directed bench for tlbsp_top: one task per scenario.
module tlbsp_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [26:0] lkp_vpn = '0;
    logic [2:0]  lkp_cmd = '0;
    logic        hit;
    logic [43:0] phys_pn;
    logic        page_fault, access_fault;
    logic        fill_valid = 1'b0;
    logic [2:0]  fill_way = '0;
    logic [26:0] fill_vpn = '0;
    logic [1:0]  fill_level = '0;
    logic [43:0] fill_ppn = '0;
    logic [6:0]  fill_perm = '0;
    logic        fill_pf = 1'b0, fill_af = 1'b0, flush_all = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [6:0] ALL = 7'h7F;

    always #4 clk = ~clk;

    tlbsp_top dut_i (.*);

    function automatic logic [26:0] mkv(input int a, input int b, input int c);
        return {9'(a), 9'(b), 9'(c)};
    endfunction

    // Expected PPN from the page-size rules, independent of the RTL.
    function automatic logic [43:0] xppn(input logic [43:0] p, input logic [26:0] v,
                                         input int lvl);
        if (lvl == 0) return {p[43:18], v[17:0]};
        if (lvl == 1) return {p[43:9], v[8:0]};
        return p;
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic fill(input int way, input logic [26:0] v, input int lvl,
                        input logic [43:0] p, input logic [6:0] pm,
                        input logic pf, input logic af);
        @(negedge clk);
        fill_valid = 1'b1; fill_way = 3'(way); fill_vpn = v; fill_level = 2'(lvl);
        fill_ppn = p; fill_perm = pm; fill_pf = pf; fill_af = af;
        @(posedge clk);
        #1 fill_valid = 1'b0;
    endtask

    task automatic look(input string rq, input logic [26:0] v, input logic [2:0] c,
                        input logic eh, input logic [43:0] ep,
                        input logic epf, input logic eaf);
        @(negedge clk);
        lkp_vpn = v; lkp_cmd = c;
        #1;
        chk(rq, "hit", 64'(hit), 64'(eh));
        chk(rq, "ppn", 64'(phys_pn), 64'(ep));
        chk(rq, "pf", 64'(page_fault), 64'(epf));
        chk(rq, "af", 64'(access_fault), 64'(eaf));
    endtask

    task automatic t_reset();   // R1, R10
        look("R1", mkv(0, 0, 0), 3'b000, 0, '0, 0, 0);
        look("R10", mkv(1, 2, 3), 3'b001, 0, '0, 0, 0);
    endtask

    task automatic t_small();   // R2
        fill(0, mkv(1, 2, 3), 2, 44'h0AB_CDEF_0123, ALL, 0, 0);
        look("R2", mkv(1, 2, 3), 3'b000, 1, 44'h0AB_CDEF_0123, 0, 0);
        look("R2", mkv(1, 2, 4), 3'b000, 0, '0, 0, 0);
    endtask

    task automatic t_mid();     // R3
        fill(1, mkv(5, 6, 7), 1, 44'h123_4567_89AB, ALL, 0, 0);
        look("R3", mkv(5, 6, 9'h1AA), 3'b000, 1,
             xppn(44'h123_4567_89AB, mkv(5, 6, 9'h1AA), 1), 0, 0);
        look("R3", mkv(5, 7, 7), 3'b000, 0, '0, 0, 0);
    endtask

    task automatic t_big();     // R4
        fill(2, mkv(9, 0, 0), 0, 44'hFED_CBA9_8765, ALL, 0, 0);
        look("R4", mkv(9, 9'h155, 9'h0AA), 3'b010, 1,
             xppn(44'hFED_CBA9_8765, mkv(9, 9'h155, 9'h0AA), 0), 0, 0);
        look("R4", mkv(8, 0, 0), 3'b000, 0, '0, 0, 0);
    endtask

    task automatic t_lvl3();    // R5
        fill(3, mkv(3, 3, 3), 3, 44'h1, ALL, 0, 0);
        look("R5", mkv(3, 3, 3), 3'b000, 0, '0, 0, 0);
    endtask

    task automatic t_perm();    // R6, R12
        logic [26:0] v;
        v = mkv(20, 1, 1);
        fill(4, v, 2, 44'h55, 7'b1100001, 0, 0);   // D A R
        look("R6", v, 3'b000, 1, 44'h55, 0, 0);
        look("R6", v, 3'b001, 1, 44'h55, 1, 0);
        look("R6", v, 3'b010, 1, 44'h55, 1, 0);
        look("R6", v, 3'b100, 1, 44'h55, 0, 0);
        look("R6", v, 3'b101, 1, 44'h55, 1, 0);
        look("R6", v, 3'b011, 1, 44'h55, 1, 0);
        fill(4, v, 2, 44'h66, 7'b0100100, 0, 0);   // A X
        look("R12", v, 3'b010, 1, 44'h66, 0, 0);
        look("R6", v, 3'b000, 1, 44'h66, 1, 0);
    endtask

    task automatic t_ad();      // R7
        logic [26:0] v;
        v = mkv(20, 1, 1);
        fill(4, v, 2, 44'h77, 7'b0111111, 0, 0);   // D clear
        look("R7", v, 3'b001, 1, 44'h77, 1, 0);
        look("R7", v, 3'b000, 1, 44'h77, 0, 0);
        fill(4, v, 2, 44'h77, 7'b1011111, 0, 0);   // A clear
        look("R7", v, 3'b000, 1, 44'h77, 1, 0);
    endtask

    task automatic t_stored();  // R8
        logic [26:0] v;
        v = mkv(30, 0, 0);
        fill(5, v, 2, 44'h88, ALL, 1, 0);
        look("R8", v, 3'b000, 1, 44'h88, 1, 0);
        fill(5, v, 2, 44'h88, ALL, 0, 1);
        look("R8", v, 3'b000, 1, 44'h88, 0, 1);
    endtask

    task automatic t_prio();    // R9, R12
        logic [26:0] v;
        v = mkv(40, 2, 2);
        fill(6, v, 2, 44'hA00_0000_0000, ALL, 0, 0);
        fill(3, mkv(40, 0, 0), 0, 44'hB00_0000_0000, ALL, 0, 0);
        look("R9", v, 3'b000, 1, xppn(44'hB00_0000_0000, v, 0), 0, 0);
        fill(3, mkv(41, 0, 0), 0, 44'hC00_0000_0000, ALL, 0, 0);
        look("R12", v, 3'b000, 1, 44'hA00_0000_0000, 0, 0);
    endtask

    task automatic t_flush();   // R11
        @(negedge clk);
        flush_all = 1'b1;
        fill_valid = 1'b1; fill_way = 3'd0; fill_vpn = mkv(50, 0, 0);
        fill_level = 2'd2; fill_ppn = 44'h99; fill_perm = ALL;
        fill_pf = 1'b0; fill_af = 1'b0;
        @(posedge clk);
        #1 flush_all = 1'b0; fill_valid = 1'b0;
        look("R11", mkv(1, 2, 3), 3'b000, 0, '0, 0, 0);
        look("R11", mkv(50, 0, 0), 3'b000, 0, '0, 0, 0);
        look("R11", mkv(40, 2, 2), 3'b000, 0, '0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_small();
        t_mid();
        t_big();
        t_lvl3();
        t_perm();
        t_ad();
        t_stored();
        t_prio();
        t_flush();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        finish_run();
    end
endmodule